// File: doc/BRIEF.md
# Power resource message decoder

This block keeps a table of 28 power resources, each with a 4-bit state. It decodes 16-bit power-bus messages and updates that table. Every message carries a processor-group mask in bits [15:13] and a format bit in bit 12. A singular message (bit 12 = 0) names one resource by its 8-bit ID. A broadcast message (bit 12 = 1) reaches every resource whose resource group, type and secondary type match the message's fields. A message changes a resource only when the message's processor-group mask and the resource's configured processor group share at least one bit.

Software loads each resource's settings through a configuration write port. The settings are the processor group, the type, the secondary type, and two remap values: one replaces a requested off state and one replaces a requested sleep state. A combinational read port returns the state of any resource. The resource group is fixed by the ID: IDs 1 to 21 are power providers (group bit 1), IDs 22 to 27 are reset and control (group bit 2), and ID 28 is the reference (group bit 4).

Top module: `pwr_msg_decoder`

## Requirements
- R1: After reset every resource state is 0x0. Every resource then has processor group 0, type 0, secondary type 0, off remap 0x0 and sleep remap 0x8.
- R2: `rd_state` gives, with no clock delay, the stored state of resource `rd_idx` (1 to 28). For `rd_idx` 0 or 29 to 31 it gives 0x0.
- R3: A singular message (bit 12 = 0, ID in [11:4], state in [3:0]) sent with `msg_valid` high updates the resource with that ID on the accepting clock edge. The new state shows on `rd_state` after that edge.
- R4: A message changes a resource only if the message mask [15:13] ANDed with the resource's processor group is nonzero. Processor groups are P1 = 1, P2 = 2 and P3 = 4. A mask of 0 reaches no resource.
- R5: A broadcast message (bit 12 = 1) updates every resource that meets all three of these conditions:
  - the resource-group mask [11:9] has the resource's group bit set;
  - the secondary type [8:7] equals the configured secondary type;
  - the type [6:4] equals the configured type, or the type field is 7.
- R6: A requested state 0x0 (off) stores the resource's off remap value. A requested state 0x8 (sleep) stores its sleep remap value. Any other requested state, such as 0xE (active) or 0xF (warm reset), is stored unchanged.
- R7: A singular message whose 8-bit ID is 0 or above 28 changes no resource, including resources whose ID equals the low bits of that ID.
- R8: A pulse on `cfg_we` with `cfg_idx` 1 to 28 loads that resource's settings and leaves every state unchanged. A message accepted on the same edge still uses the old settings.
- R9: While `msg_valid` is low, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | `msg` is accepted on this clock edge |
| msg | input | 16 | Power-bus message |
| cfg_we | input | 1 | Load settings for resource `cfg_idx` |
| cfg_idx | input | 5 | Resource ID to configure (1 to 28) |
| cfg_pgrp | input | 3 | Processor-group mask of the resource |
| cfg_type | input | 3 | Resource type matched by broadcasts |
| cfg_type2 | input | 2 | Secondary type matched by broadcasts |
| cfg_remap_off | input | 4 | State stored when off is requested |
| cfg_remap_sleep | input | 4 | State stored when sleep is requested |
| rd_idx | input | 5 | Resource ID to read |
| rd_state | output | 4 | State of resource `rd_idx` |

## Verification
A message takes effect on the clock edge that accepts it, and a configuration write takes effect on its edge. `rd_state` follows `rd_idx` with no clock delay. The bench drives each message on a falling edge and drops `msg_valid` on the next falling edge. After one rising edge in between, it sets `rd_idx` and samples `rd_state` a short time later, well before the next rising edge. Cases that must leave a state unchanged are read back the same way, on the resource that a wrong decode would have hit.

// File: rtl/pwr_msg_decoder.sv
module pwr_msg_decoder #(
  parameter int N_PP  = 21,
  parameter int N_RC  = 6,
  parameter int N_REF = 1,
  localparam int N_RES = N_PP + N_RC + N_REF,
  localparam int IDX_W = $clog2(N_RES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [15:0]      msg,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [2:0]       cfg_pgrp,
  input  logic [2:0]       cfg_type,
  input  logic [1:0]       cfg_type2,
  input  logic [3:0]       cfg_remap_off,
  input  logic [3:0]       cfg_remap_sleep,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [3:0]       rd_state
);

  logic [3:0] states [1:N_RES];

  wire [2:0] m_pgrp  = msg[15:13];
  wire       m_bcast = msg[12];
  wire [2:0] m_rgrp  = msg[11:9];
  wire [1:0] m_type2 = msg[8:7];
  wire [2:0] m_type  = msg[6:4];
  wire [7:0] m_id    = msg[11:4];
  wire [3:0] m_state = msg[3:0];

  for (genvar i = 1; i <= N_RES; i++) begin : g_res
    localparam logic [2:0] RGRP = (i <= N_PP) ? 3'd1 : ((i <= N_PP + N_RC) ? 3'd2 : 3'd4);
    logic [2:0] pgrp, rtype;
    logic [1:0] rtype2;
    logic [3:0] roff, rslp, st;

    wire hit_b = m_bcast && |(m_rgrp & RGRP) && (m_type2 == rtype2) &&
                 (m_type == 3'd7 || m_type == rtype);
    wire hit_s = !m_bcast && (m_id == 8'(i));
    wire apply = msg_valid && |(m_pgrp & pgrp) && (hit_b || hit_s);
    wire [3:0] nxt = (m_state == 4'h0) ? roff :
                     (m_state == 4'h8) ? rslp : m_state;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pgrp <= '0; rtype <= '0; rtype2 <= '0;
        roff <= 4'h0; rslp <= 4'h8; st <= 4'h0;
      end else begin
        if (cfg_we && cfg_idx == IDX_W'(i)) begin
          pgrp <= cfg_pgrp; rtype <= cfg_type; rtype2 <= cfg_type2;
          roff <= cfg_remap_off; rslp <= cfg_remap_sleep;
        end
        if (apply) st <= nxt;
      end
    end

    assign states[i] = st;
  end

  assign rd_state = (rd_idx != '0 && rd_idx <= IDX_W'(N_RES)) ? states[rd_idx] : 4'h0;

endmodule

module pwr_msg_decoder_chk #(
  parameter int N_RES = 28,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic [15:0]      msg,
  input logic [IDX_W-1:0] rd_idx,
  input logic [3:0]       rd_state
);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> ($stable(rd_idx) -> $stable(rd_state)));

  p_no_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg[15:13] == 3'd0) |=> ($stable(rd_idx) -> $stable(rd_state)));

  p_bad_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg[12] && (msg[11:4] == 8'd0 || msg[11:4] > 8'(N_RES)))
    |=> ($stable(rd_idx) -> $stable(rd_state)));

  p_read_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == '0 || rd_idx > IDX_W'(N_RES)) |-> rd_state == 4'h0);

endmodule

bind pwr_msg_decoder pwr_msg_decoder_chk #(.N_RES(N_RES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg(msg),
  .rd_idx(rd_idx), .rd_state(rd_state));

// File: tb/pwr_msg_decoder_test.sv
module pwr_msg_decoder_test;
  localparam int CLK_PERIOD = 10;

  function automatic logic [15:0] sing(input logic [2:0] pg, input logic [7:0] id, input logic [3:0] st);
    return {pg, 1'b0, id, st};
  endfunction
  function automatic logic [15:0] bc(input logic [2:0] pg, input logic [2:0] rg, input logic [1:0] t2,
                                     input logic [2:0] ty, input logic [3:0] st);
    return {pg, 1'b1, rg, t2, ty, st};
  endfunction

  // {message, read index, expected state, requirement number}
  localparam int NV = 23;
  localparam logic [28:0] VEC [NV] = '{
    {sing(3'd1, 8'd1, 4'hE),             5'd1,  4'hE, 4'd3}, // R3
    {sing(3'd2, 8'd1, 4'hF),             5'd1,  4'hE, 4'd4}, // R4 no overlap
    {sing(3'd1, 8'd1, 4'h0),             5'd1,  4'h2, 4'd6}, // R6 off remap
    {sing(3'd1, 8'd1, 4'h8),             5'd1,  4'h9, 4'd6}, // R6 sleep remap
    {sing(3'd2, 8'd5, 4'hE),             5'd5,  4'hE, 4'd3}, // R3
    {sing(3'd7, 8'd5, 4'hF),             5'd5,  4'hF, 4'd4}, // R4 partial overlap
    {sing(3'd7, 8'd5, 4'h0),             5'd5,  4'h0, 4'd6}, // R6
    {bc(3'd2, 3'd1, 2'd1, 3'd2, 4'hE),   5'd5,  4'hE, 4'd5}, // R5
    {bc(3'd2, 3'd1, 2'd0, 3'd2, 4'hF),   5'd5,  4'hE, 4'd5}, // R5 type2 mismatch
    {bc(3'd2, 3'd2, 2'd1, 3'd2, 4'hF),   5'd5,  4'hE, 4'd5}, // R5 group mismatch
    {bc(3'd2, 3'd7, 2'd1, 3'd7, 4'h8),   5'd5,  4'h8, 4'd5}, // R5 type all
    {bc(3'd4, 3'd2, 2'd0, 3'd3, 4'hE),   5'd22, 4'hE, 4'd5}, // R5
    {bc(3'd4, 3'd2, 2'd0, 3'd5, 4'hF),   5'd22, 4'hE, 4'd5}, // R5 type mismatch
    {bc(3'd4, 3'd7, 2'd0, 3'd7, 4'hF),   5'd22, 4'hF, 4'd5}, // R5
    {bc(3'd1, 3'd4, 2'd0, 3'd1, 4'h0),   5'd28, 4'h1, 4'd6}, // R6 via broadcast
    {bc(3'd2, 3'd4, 2'd0, 3'd7, 4'hE),   5'd28, 4'hE, 4'd5}, // R5
    {bc(3'd1, 3'd7, 2'd0, 3'd7, 4'hE),   5'd1,  4'hE, 4'd5}, // R5
    {bc(3'd7, 3'd7, 2'd0, 3'd7, 4'hF),   5'd2,  4'h0, 4'd4}, // R4 group 0 resource
    {bc(3'd7, 3'd7, 2'd0, 3'd7, 4'hF),   5'd28, 4'hF, 4'd5}, // R5
    {sing(3'd7, 8'd0, 4'hE),             5'd1,  4'hF, 4'd7}, // R7
    {sing(3'd7, 8'd33, 4'hE),            5'd1,  4'hF, 4'd7}, // R7 alias of 1
    {sing(3'd7, 8'd60, 4'h0),            5'd28, 4'hF, 4'd7}, // R7 alias of 28
    {sing(3'd0, 8'd1, 4'hE),             5'd1,  4'hF, 4'd4}  // R4 empty mask
  };

  logic clk = 0, rst_n = 0, msg_valid = 0, cfg_we = 0;
  logic [15:0] msg = '0;
  logic [4:0]  cfg_idx = '0, rd_idx = '0;
  logic [2:0]  cfg_pgrp = '0, cfg_type = '0;
  logic [1:0]  cfg_type2 = '0;
  logic [3:0]  cfg_remap_off = '0, cfg_remap_sleep = '0;
  logic [3:0]  rd_state;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_msg_decoder uut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg(msg),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_pgrp(cfg_pgrp), .cfg_type(cfg_type),
    .cfg_type2(cfg_type2), .cfg_remap_off(cfg_remap_off), .cfg_remap_sleep(cfg_remap_sleep),
    .rd_idx(rd_idx), .rd_state(rd_state));

  task automatic check(input int req, input logic [4:0] idx, input logic [3:0] exp);
    rd_idx = idx;
    #1;
    n_chk++;
    if (rd_state !== exp) begin
      n_bad++;
      $display("FAIL R%0d idx %0d: got %h expected %h", req, idx, rd_state, exp);
    end
  endtask

  task automatic cfg(input logic [4:0] idx, input logic [2:0] pg, input logic [2:0] ty,
                     input logic [1:0] t2, input logic [3:0] ro, input logic [3:0] rs);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx; cfg_pgrp = pg; cfg_type = ty; cfg_type2 = t2;
    cfg_remap_off = ro; cfg_remap_sleep = rs;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic [15:0] m);
    @(negedge clk);
    msg_valid = 1; msg = m;
    @(negedge clk);
    msg_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 32; i++) check(1, 5'(i), 4'h0); // R1 and R2 reset state
    cfg(5'd1,  3'd1, 3'd1, 2'd0, 4'h2, 4'h9);
    cfg(5'd5,  3'd2, 3'd2, 2'd1, 4'h0, 4'h8);
    cfg(5'd22, 3'd4, 3'd3, 2'd0, 4'h0, 4'h8);
    cfg(5'd28, 3'd3, 3'd1, 2'd0, 4'h1, 4'h8);
    for (int i = 1; i < 29; i++) check(8, 5'(i), 4'h0); // R8 config leaves states alone

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][28:13]);
      check(int'(VEC[v][3:0]), VEC[v][12:8], VEC[v][7:4]);
    end

    // R2: out-of-range reads return 0 while states are nonzero
    check(2, 5'd0, 4'h0);
    check(2, 5'd29, 4'h0);
    check(2, 5'd31, 4'h0);
    check(2, 5'd28, 4'hF);

    // R9: message present but msg_valid low
    @(negedge clk);
    msg = sing(3'd7, 8'd1, 4'h3);
    @(negedge clk);
    check(9, 5'd1, 4'hF);

    // R8: same-edge config and message uses old remap, then new remap applies
    @(negedge clk);
    cfg_we = 1; cfg_idx = 5'd1; cfg_pgrp = 3'd1; cfg_type = 3'd1; cfg_type2 = 2'd0;
    cfg_remap_off = 4'h5; cfg_remap_sleep = 4'h9;
    msg_valid = 1; msg = sing(3'd1, 8'd1, 4'h0);
    @(negedge clk);
    cfg_we = 0; msg_valid = 0;
    check(8, 5'd1, 4'h2);
    send(sing(3'd1, 8'd1, 4'h0));
    check(8, 5'd1, 4'h5);
    // R8: config write alone does not touch the state
    cfg(5'd1, 3'd1, 3'd1, 2'd0, 4'h7, 4'h9);
    check(8, 5'd1, 4'h5);

    // R1: reset mid-run clears states and settings
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    check(1, 5'd1, 4'h0);
    check(1, 5'd22, 4'h0);
    send(sing(3'd7, 8'd1, 4'hE)); // group 0 after reset: no effect
    check(1, 5'd1, 4'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule